// File: doc/BRIEF.md
# Running-Average Threshold Decision Unit

This unit watches a stream of nonnegative distance scores. It keeps the running sum and the number of scores taken since the last clear. Each time a score arrives, it tests the average of all scores so far against a pair of early bounds. An average under the low early bound accepts the stream. An average over the high early bound rejects it. Any value in between waits for more scores.

If no early verdict has come by the time the score count reaches a fixed limit (703 by default), the unit makes a final verdict against a second, inner pair of bounds. An average under the lower inner bound accepts, an average over the upper inner bound rejects, and anything from one inner bound to the other, both ends included, is reported as unknown. The unit never divides. It compares the sum against each bound multiplied by the count.

Once a verdict is out, it stays on the outputs and further scores are dropped until the clear input is pulsed.

Top module: `avg_verdict_unit`

## Requirements
- R1: After reset, and in the cycle after `startClr` is high, `done` is 0, `verdict` is 2'b00 and the sum and count are zero.
- R2: When a sample is taken and the new sum is strictly less than `thrRunLow` times the new count, the unit raises `done` with `verdict` = 2'b01 (accepted).
- R3: When a sample is taken, no accept applies, and the new sum is strictly greater than `thrRunHigh` times the new count, the unit raises `done` with `verdict` = 2'b10 (rejected).
- R4: An average exactly equal to a running bound gives no early verdict, and `done` stays 0.
- R5: When the MAX_COUNT-th sample arrives with no early verdict, and the sum lies between `thrFinLow` and `thrFinHigh` times the count (both ends included), `done` rises with `verdict` = 2'b11 (unknown). Before that sample, `done` stays 0.
- R6: At the MAX_COUNT-th sample, a sum strictly below `thrFinLow` times the count gives 2'b01, and a sum strictly above `thrFinHigh` times the count gives 2'b10.
- R7: While `done` is 1 and `startClr` is 0, `done` and `verdict` hold, and samples are not counted or summed.
- R8: A sample is taken on a rising edge where `distValid` is 1, and any verdict it causes shows on the outputs right after that edge.
- R9: When `startClr` and `distValid` are high on the same edge, the clear wins and the sample is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startClr | input | 1 | Synchronous clear of the sum, count and verdict |
| distValid | input | 1 | Distance sample strobe |
| distIn | input | DIST_W | Distance sample |
| thrRunLow | input | DIST_W | Early accept bound |
| thrFinLow | input | DIST_W | Final accept bound |
| thrFinHigh | input | DIST_W | Final reject bound |
| thrRunHigh | input | DIST_W | Early reject bound |
| done | output | 1 | Verdict issued |
| verdict | output | 2 | 00 none, 01 accepted, 10 rejected, 11 unknown |

## Verification
The timeout verdicts are the hardest to reach. They need a full MAX_COUNT samples with the average never leaving the running window. The bench gets there by setting the running bounds to values the average cannot cross: zero for the low bound, because no sum is below zero, and the largest threshold for the high bound. It then feeds constant streams that land below, inside, exactly on and above the inner bounds. Random trials with ordered random bounds fill in the early-verdict paths, and each one is checked against a model in the bench.

// File: rtl/avg_verdict_pkg.sv
package avg_verdict_pkg;
  typedef enum logic [1:0] {
    V_NONE    = 2'b00,
    V_ACCEPT  = 2'b01,
    V_REJECT  = 2'b10,
    V_UNKNOWN = 2'b11
  } verdict_e;

  typedef struct packed {
    logic clear;
    logic accumulate;
  } dp_ctrl_t;

  typedef struct packed {
    logic belowRunLow;
    logic aboveRunHigh;
    logic belowFinLow;
    logic aboveFinHigh;
    logic atLimit;
  } dp_cmp_t;
endpackage

// File: rtl/avg_verdict_dp.sv
module avg_verdict_dp
  import avg_verdict_pkg::*;
#(
  parameter int DIST_W    = 16,
  parameter int MAX_COUNT = 703
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dp_ctrl_t          ctrl,
  input  logic [DIST_W-1:0] distIn,
  input  logic [DIST_W-1:0] thrRunLow,
  input  logic [DIST_W-1:0] thrFinLow,
  input  logic [DIST_W-1:0] thrFinHigh,
  input  logic [DIST_W-1:0] thrRunHigh,
  output dp_cmp_t           cmp
);
  localparam int CNT_W = $clog2(MAX_COUNT + 1);
  localparam int SUM_W = DIST_W + CNT_W;

  logic [SUM_W-1:0] sumQ, newSum;
  logic [CNT_W-1:0] countQ, newCount;
  logic [SUM_W-1:0] scaled [4];

  assign newSum   = sumQ + SUM_W'(distIn);
  assign newCount = countQ + CNT_W'(1);

  // each bound times the new count, no division needed
  logic [DIST_W-1:0] thrVec [4];
  assign thrVec[0] = thrRunLow;
  assign thrVec[1] = thrFinLow;
  assign thrVec[2] = thrFinHigh;
  assign thrVec[3] = thrRunHigh;

  for (genvar i = 0; i < 4; i++) begin : g_scale
    assign scaled[i] = SUM_W'(thrVec[i]) * SUM_W'(newCount);
  end

  always_comb begin
    cmp.belowRunLow  = newSum < scaled[0];
    cmp.belowFinLow  = newSum < scaled[1];
    cmp.aboveFinHigh = newSum > scaled[2];
    cmp.aboveRunHigh = newSum > scaled[3];
    cmp.atLimit      = newCount == CNT_W'(MAX_COUNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sumQ   <= '0;
      countQ <= '0;
    end else if (ctrl.clear) begin
      sumQ   <= '0;
      countQ <= '0;
    end else if (ctrl.accumulate) begin
      sumQ   <= newSum;
      countQ <= newCount;
    end
  end

  // R5: count never passes the observation limit
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    countQ <= CNT_W'(MAX_COUNT));

  // R7: state frozen when no strobe
  p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.clear && !ctrl.accumulate) |=> ($stable(sumQ) && $stable(countQ)));

  // R1: clear empties the state
  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.clear |=> (sumQ == '0 && countQ == '0));
endmodule

// File: rtl/avg_verdict_ctl.sv
module avg_verdict_ctl
  import avg_verdict_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     startClr,
  input  logic     distValid,
  input  dp_cmp_t  cmp,
  output dp_ctrl_t ctrl,
  output logic     done,
  output verdict_e verdict
);
  verdict_e nextVerdict;
  logic     take;

  assign take            = distValid && !done && !startClr;
  assign ctrl.clear      = startClr;
  assign ctrl.accumulate = take;

  always_comb begin
    nextVerdict = V_NONE;
    if (cmp.belowRunLow)       nextVerdict = V_ACCEPT;
    else if (cmp.aboveRunHigh) nextVerdict = V_REJECT;
    else if (cmp.atLimit) begin
      if (cmp.belowFinLow)       nextVerdict = V_ACCEPT;
      else if (cmp.aboveFinHigh) nextVerdict = V_REJECT;
      else                       nextVerdict = V_UNKNOWN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      verdict <= V_NONE;
    end else if (startClr) begin
      done    <= 1'b0;
      verdict <= V_NONE;
    end else if (take && nextVerdict != V_NONE) begin
      done    <= 1'b1;
      verdict <= nextVerdict;
    end
  end

  // R7: verdict held until clear
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !startClr) |=> (done && $stable(verdict)));

  // R9: clear wins over a sample
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    startClr |=> (!done && verdict == V_NONE));

  // R8: done and a nonzero code move together
  p_done_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done == (verdict != V_NONE));

  // R5: unknown only when the limit is reached
  p_unknown_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cmp.atLimit) |=> (verdict != V_UNKNOWN));
endmodule

// File: rtl/avg_verdict_unit.sv
module avg_verdict_unit
  import avg_verdict_pkg::*;
#(
  parameter int DIST_W    = 16,
  parameter int MAX_COUNT = 703
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startClr,
  input  logic              distValid,
  input  logic [DIST_W-1:0] distIn,
  input  logic [DIST_W-1:0] thrRunLow,
  input  logic [DIST_W-1:0] thrFinLow,
  input  logic [DIST_W-1:0] thrFinHigh,
  input  logic [DIST_W-1:0] thrRunHigh,
  output logic              done,
  output logic [1:0]        verdict
);
  dp_ctrl_t ctrl;
  dp_cmp_t  cmp;
  verdict_e verdictE;

  avg_verdict_dp #(.DIST_W(DIST_W), .MAX_COUNT(MAX_COUNT)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .distIn(distIn),
    .thrRunLow(thrRunLow), .thrFinLow(thrFinLow),
    .thrFinHigh(thrFinHigh), .thrRunHigh(thrRunHigh), .cmp(cmp));

  avg_verdict_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .startClr(startClr), .distValid(distValid),
    .cmp(cmp), .ctrl(ctrl), .done(done), .verdict(verdictE));

  assign verdict = verdictE;
endmodule

// File: tb/avg_verdict_unit_tb.sv
module avg_verdict_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIST_W = 16;
  localparam int MAXC = 703;

  logic clk = 0, rst_n = 0, startClr = 0, distValid = 0;
  logic [DIST_W-1:0] distIn = 0, tRL = 0, tFL = 0, tFH = 0, tRH = 0;
  logic done;
  logic [1:0] verdict;

  int checks = 0, errors = 0;
  longint mSum = 0, mCnt = 0;
  bit mDone = 0;
  logic [1:0] mVerdict = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  avg_verdict_unit #(.DIST_W(DIST_W), .MAX_COUNT(MAXC)) u_dut (
    .clk(clk), .rst_n(rst_n), .startClr(startClr), .distValid(distValid),
    .distIn(distIn), .thrRunLow(tRL), .thrFinLow(tFL), .thrFinHigh(tFH),
    .thrRunHigh(tRH), .done(done), .verdict(verdict));

  function automatic logic [1:0] refVerdict(longint s, longint n);
    if (s < longint'(tRL) * n) return 2'b01;
    if (s > longint'(tRH) * n) return 2'b10;
    if (n == MAXC) begin
      if (s < longint'(tFL) * n) return 2'b01;
      if (s > longint'(tFH) * n) return 2'b10;
      return 2'b11;
    end
    return 2'b00;
  endfunction

  task automatic check(bit expDone, logic [1:0] expV, string tag);
    checks++;
    if (done !== expDone || verdict !== expV) begin
      errors++;
      $display("FAIL %s: done=%0b verdict=%0b expected done=%0b verdict=%0b",
               tag, done, verdict, expDone, expV);
    end
  endtask

  task automatic modelClear();
    mSum = 0; mCnt = 0; mDone = 0; mVerdict = 0;
  endtask

  // one sample, outputs checked half a cycle after the capturing edge (R8)
  task automatic send(int d, bit doCheck, string tag);
    @(negedge clk);
    distValid = 1; distIn = DIST_W'(d);
    @(negedge clk);
    distValid = 0;
    if (!mDone) begin
      mSum += d; mCnt++;
      mVerdict = refVerdict(mSum, mCnt);
      mDone = (mVerdict != 2'b00);
    end
    if (doCheck) check(mDone, mVerdict, tag);
  endtask

  task automatic clearPulse();
    @(negedge clk); startClr = 1;
    @(negedge clk); startClr = 0;
    modelClear();
  endtask

  task automatic setThr(int a, int b, int c, int d);
    tRL = DIST_W'(a); tFL = DIST_W'(b); tFH = DIST_W'(c); tRH = DIST_W'(d);
  endtask

  task automatic runTimeout(int d, logic [1:0] expV, string tag);
    clearPulse();
    for (int i = 0; i < MAXC - 1; i++) send(d, 0, tag);
    check(0, 2'b00, {tag, " before limit R5"});
    send(d, 0, tag);
    check(1, expV, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    setThr(10, 12, 18, 20);
    repeat (3) @(negedge clk);
    check(0, 2'b00, "R1 reset state");
    rst_n = 1;
    @(negedge clk);
    check(0, 2'b00, "R1 after reset release");

    // R4: average equals the low running bound
    send(10, 1, "R4 equal low bound");
    check(0, 2'b00, "R4 no verdict at equality");
    send(0, 1, "R2 early accept");
    check(1, 2'b01, "R2 accept code");

    // R7: later samples ignored
    for (int i = 0; i < 5; i++) send(1000, 1, "R7 hold after done");
    check(1, 2'b01, "R7 verdict unchanged");

    clearPulse();
    check(0, 2'b00, "R1 clear");
    send(20, 1, "R4 equal high bound");
    check(0, 2'b00, "R4 no reject at equality");
    send(25, 1, "R3 early reject");
    check(1, 2'b10, "R3 reject code");

    // R9: clear and sample on the same edge, sample must be dropped
    @(negedge clk); startClr = 1; distValid = 1; distIn = 100;
    @(negedge clk); startClr = 0; distValid = 0;
    modelClear();
    check(0, 2'b00, "R9 clear wins");
    send(0, 1, "R9 dropped sample not summed");
    check(1, 2'b01, "R9 accept proves sum was zero");

    // timeouts: running bounds unreachable
    setThr(0, 10, 20, 16'hFFFF);
    runTimeout(15, 2'b11, "R5 unknown inside");
    runTimeout(20, 2'b11, "R5 unknown on upper final bound");
    runTimeout(10, 2'b11, "R5 unknown on lower final bound");
    runTimeout(5,  2'b01, "R6 final accept");
    runTimeout(25, 2'b10, "R6 final reject");
    send(1, 1, "R7 ignored after timeout");

    // random trials against the model
    for (int t = 0; t < 30; t++) begin
      int a, b, c, d;
      a = $urandom_range(0, 50);
      b = a + $urandom_range(0, 20);
      c = b + $urandom_range(0, 20);
      d = c + $urandom_range(0, 50);
      setThr(a, b, c, d);
      clearPulse();
      for (int i = 0; i < MAXC && !mDone; i++)
        send($urandom_range(0, d + 20), 1, "R2 R3 R6 random trial");
      check(1, mVerdict, "R8 random final");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule